// File: doc/BRIEF.md
# Paged Three-Wire Register Master

This block is the host-side master for a peripheral that sits on a bidirectional three-wire serial link: a clock line, a shared data line and a read/write select line. The peripheral's registers are split into two pages. The host sees one flat logical address space. Logical addresses below the page span belong to page 1. Addresses at or above it belong to page 2 and go out with the span subtracted. The master keeps a cached copy of the peripheral's page register. When a request targets the other page, it first sends a full page-switch frame on its own.

The host issues one request at a time over a valid/ready handshake. There are four operations: plain write, read, set-bits and clear-bits. A shadow copy of every written logical value lets the set and clear operations run as read-modify-write without touching the link for the read half. Three registers have their data changed before transmission: one is inverted, one is folded into two descending ranges, and one has constant bits forced high. The shadow always holds the host's logical value. Every operation ends with a one-cycle done pulse; for a read, the returned byte is valid in that cycle.

The bit timing comes from a programmable clock-enable divider. Each clock phase on the link lasts `div_cfg + 1` system clocks.

Top module: `tw3_master`

## Requirements
- R1: A request is taken only when `req_ready` is high, and `req_ready` equals the inverse of `busy`. `busy` stays high from the cycle after acceptance until the cycle of the one-cycle `op_done` pulse. This covers every frame of the operation, including an implicit page switch. Operation codes: 0 write, 1 read, 2 set-bits, 3 clear-bits.
- R2: Each byte is shifted out least significant bit first. For each bit, the clock is low for one bit delay with the data bit already driven, then high for one bit delay. Data does not change while the clock is high, and the clock idles high.
- R3: A write frame raises select and enables the data driver for one bit delay before the first bit. It sends the data byte, then the local address byte. It then disables the driver and drops select for one bit delay. The driver is never enabled while select is low.
- R4: A logical address below 16 maps to page 1 with an unchanged local address. An address of 16 or more maps to page 2 with local address `addr - 16`. If the target page differs from the cached page, the master first writes the page number (1 or 2) to local address 0x01 in a complete write frame, then updates the cache.
- R5: After reset the page cache holds 0, so the first access always begins with a page-switch frame.
- R6: A read sends a frame that carries only the local address byte. It then runs 8 clock periods with select low and the driver off, sampling `sdata_i` at the end of each low phase, least significant bit first. The assembled byte appears on `rd_data` with `op_done`.
- R7: For a write to logical address 0x03, the byte sent is 255 minus the logical value.
- R8: For a write to logical address 0x09, a logical value below 64 is sent as 255 minus the value. A value from 64 to 191 is sent as 191 minus the value.
- R9: For a write to logical address 0x12 (page 2, local 0x02), the byte sent has bits 4, 1 and 0 forced to 1.
- R10: The shadow holds the last logical value written to each address and resets to 0. Set-bits sends `shadow | data` and clear-bits sends `~data & shadow`, both remapped as in R7 to R9. The result becomes the new shadow value. Reads leave the shadow unchanged.
- R11: Every logical address other than 0x03, 0x09 and 0x12 is sent unchanged. This includes 0x13 and 0x19, which share their local addresses with remapped page-1 registers.
- R12: With `div_cfg = n`, every clock phase and every setup or release interval lasts n+1 system clocks. Every frame therefore keeps the link busy for 34·(n+1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Master can take a request |
| req_op | input | 2 | 0 write, 1 read, 2 set-bits, 3 clear-bits |
| req_addr | input | 5 | Logical register address |
| req_data | input | 8 | Write value or bit mask |
| div_cfg | input | 8 | Bit delay minus one, in system clocks |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result, valid with `op_done` |
| sclk | output | 1 | Link clock |
| rw_sel | output | 1 | Link select, high during a write frame |
| sdata_o | output | 1 | Data line output value |
| sdata_oe | output | 1 | Data line driver enable |
| sdata_i | input | 1 | Data line input value |

## Verification
The bench builds the block with its defaults: a page span of 16 and an 8-bit divider. It then runs at `div_cfg` values 0, 3 and 1. At 0 every link phase is one system clock wide, which exercises back-to-back byte changes and sampling in the cycle right after the clock falls. The stretched settings check that phase widths and the 34-tick frame length scale with the divider. A peripheral model decodes the pins into frames, and the bench compares them against a behavioural queue of expected frames. These runs cover both page switches, the fold boundaries at 63, 64 and 191, and read-back of remapped physical bytes.

// File: rtl/tw3_pkg.sv
// Shared constants and types for the paged three-wire master.
// Assumes an 8-bit register data path and two register pages.
package tw3_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] PAGE_REG_ADDR = 8'h01;
    localparam logic [BYTE_W-1:0] PAGE1_ID      = 8'd1;
    localparam logic [BYTE_W-1:0] PAGE2_ID      = 8'd2;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SEND,
        ST_END,
        ST_RECV
    } state_e;

    typedef enum logic [1:0] {
        FR_PAGE,
        FR_WRITE,
        FR_READ
    } frame_e;
endpackage

// File: rtl/tw3_tick.sv
// Bit-delay clock enable. It counts system clocks while enabled and
// pulses tick every div+1 cycles. It restarts from zero whenever disabled.
// Assumes div is held constant while en is high.
module tw3_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // Advance the delay counter; clear on tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tw3_shifter.sv
// Byte serializer and deserializer for the link clock.
// Each bit takes two ticks: a low phase with data driven, then a high phase.
// Receive data is sampled on the tick that ends each low phase, LSB first.
// Assumes tx_byte changes only when last is seen with a tick.
module tw3_shifter
    import tw3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              last,
    output logic [BYTE_W-1:0] rx_byte
);
    logic             ph_q;
    logic [BIT_W-1:0] bit_q;
    logic [BYTE_W-1:0] rx_q;

    // Step through low/high phases and bit positions on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q  <= 1'b0;
            bit_q <= '0;
        end else if (tick) begin
            if (!ph_q) begin
                ph_q <= 1'b1;
            end else begin
                ph_q  <= 1'b0;
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Capture the input line at the end of every low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (run && tick && !ph_q) begin
            rx_q[bit_q] <= sdi;
        end
    end

    assign sclk    = run ? ph_q : 1'b1;
    assign sdo     = tx_byte[bit_q];
    assign last    = ph_q && (bit_q == BIT_W'(BYTE_W - 1));
    assign rx_byte = rx_q;

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && ph_q) |-> $stable(sdo)); // R2
endmodule

// File: rtl/tw3_remap.sv
// Logical-to-physical data remapping, applied before transmission.
// It inverts one register, folds another into two descending ranges, and
// forces constant bits high on a third. All other addresses pass through.
module tw3_remap
    import tw3_pkg::*;
#(
    parameter int                ADDR_W     = 5,
    parameter int                INV_ADDR   = 3,
    parameter int                FOLD_ADDR  = 9,
    parameter int                FORCE_ADDR = 18,
    parameter logic [BYTE_W-1:0] FORCE_MASK = 8'h13,
    parameter int                FOLD_SPLIT = 64,
    parameter int                FOLD_TOP   = 191
) (
    input  logic [ADDR_W-1:0] log_addr,
    input  logic [BYTE_W-1:0] log_val,
    output logic [BYTE_W-1:0] phy_val
);
    // Select the transform for the addressed register.
    always_comb begin
        phy_val = log_val;
        if (log_addr == ADDR_W'(INV_ADDR)) begin
            phy_val = 8'hFF - log_val;
        end else if (log_addr == ADDR_W'(FOLD_ADDR)) begin
            if (log_val < BYTE_W'(FOLD_SPLIT)) begin
                phy_val = 8'hFF - log_val;
            end else begin
                phy_val = BYTE_W'(FOLD_TOP) - log_val;
            end
        end else if (log_addr == ADDR_W'(FORCE_ADDR)) begin
            phy_val = log_val | FORCE_MASK;
        end
    end
endmodule

// File: rtl/tw3_shadow.sv
// Shadow store of the logical values written to each register.
// One synchronous write port and one combinational read port. Clears on reset.
module tw3_shadow
    import tw3_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem_q [DEPTH];

    // Clear every entry on reset; store the logical value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tw3_master.sv
// Paged three-wire register master.
// It takes one host request at a time and inserts a page-switch frame when
// the target page differs from the cached page. It sends the data byte
// before the address byte and remaps data for the special registers.
// It returns read data with a one-cycle done pulse.
// Assumes PAGE_SPAN is a power of two and div_cfg is stable while busy.
module tw3_master
    import tw3_pkg::*;
#(
    parameter int PAGE_SPAN = 16,
    parameter int DIV_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(2*PAGE_SPAN)-1:0] req_addr,
    input  logic [BYTE_W-1:0]            req_data,
    input  logic [DIV_W-1:0]             div_cfg,
    output logic                         busy,
    output logic                         op_done,
    output logic [BYTE_W-1:0]            rd_data,
    output logic                         sclk,
    output logic                         rw_sel,
    output logic                         sdata_o,
    output logic                         sdata_oe,
    input  logic                         sdata_i
);
    localparam int ADDR_W = $clog2(2 * PAGE_SPAN);
    localparam int LOC_W  = $clog2(PAGE_SPAN);
    localparam int DEPTH  = 2 * PAGE_SPAN;

    state_e            state_q;
    frame_e            frame_q;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] val_q;
    logic              byte_idx_q;
    logic [BYTE_W-1:0] page_q;
    logic              done_q;
    logic [BYTE_W-1:0] rdat_q;

    logic              tick;
    logic              run;
    logic              sh_last;
    logic [BYTE_W-1:0] sh_rx;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] shadow_rd;
    logic [BYTE_W-1:0] acc_val;
    logic [BYTE_W-1:0] phy_val;
    logic [BYTE_W-1:0] req_page;
    logic [BYTE_W-1:0] tgt_page;
    logic [BYTE_W-1:0] loc_byte;
    logic              shadow_we;

    assign busy      = (state_q != ST_IDLE);
    assign req_ready = !busy;
    assign run       = (state_q == ST_SEND) || (state_q == ST_RECV);
    assign rw_sel    = (state_q == ST_SETUP) || (state_q == ST_SEND);
    assign sdata_oe  = rw_sel;
    assign op_done   = done_q;
    assign rd_data   = rdat_q;

    assign req_page  = req_addr[ADDR_W-1] ? PAGE2_ID : PAGE1_ID;
    assign tgt_page  = addr_q[ADDR_W-1] ? PAGE2_ID : PAGE1_ID;
    assign loc_byte  = BYTE_W'(addr_q[LOC_W-1:0]);
    assign shadow_we = (state_q == ST_END) && tick && (frame_q == FR_WRITE);

    tw3_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .div  (div_cfg),
        .tick (tick)
    );

    tw3_shifter u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .tx_byte(tx_byte),
        .sdi    (sdata_i),
        .sclk   (sclk),
        .sdo    (sdata_o),
        .last   (sh_last),
        .rx_byte(sh_rx)
    );

    tw3_shadow #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (shadow_we),
        .waddr(addr_q),
        .wdata(val_q),
        .raddr(req_addr),
        .rdata(shadow_rd)
    );

    tw3_remap #(
        .ADDR_W    (ADDR_W),
        .INV_ADDR  (3),
        .FOLD_ADDR (9),
        .FORCE_ADDR(PAGE_SPAN + 2)
    ) u_remap (
        .log_addr(addr_q),
        .log_val (val_q),
        .phy_val (phy_val)
    );

    // Logical value of a request: plain data, or a read-modify-write of the shadow.
    always_comb begin
        case (op_e'(req_op))
            OP_SET:   acc_val = shadow_rd | req_data;
            OP_CLEAR: acc_val = shadow_rd & ~req_data;
            default:  acc_val = req_data;
        endcase
    end

    // Byte presented to the serializer for the current frame and byte slot.
    always_comb begin
        case (frame_q)
            FR_PAGE:  tx_byte = byte_idx_q ? PAGE_REG_ADDR : tgt_page;
            FR_WRITE: tx_byte = byte_idx_q ? loc_byte : phy_val;
            default:  tx_byte = loc_byte;
        endcase
    end

    // Request sequencer: page switch, framing, receive and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            frame_q    <= FR_WRITE;
            op_q       <= OP_WRITE;
            addr_q     <= '0;
            val_q      <= '0;
            byte_idx_q <= 1'b0;
            page_q     <= '0;
            done_q     <= 1'b0;
            rdat_q     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q       <= op_e'(req_op);
                        addr_q     <= req_addr;
                        val_q      <= acc_val;
                        byte_idx_q <= 1'b0;
                        state_q    <= ST_SETUP;
                        if (req_page != page_q) begin
                            frame_q <= FR_PAGE;
                        end else if (op_e'(req_op) == OP_READ) begin
                            frame_q <= FR_READ;
                        end else begin
                            frame_q <= FR_WRITE;
                        end
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        state_q    <= ST_SEND;
                        byte_idx_q <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (tick && sh_last) begin
                        if (frame_q == FR_READ || byte_idx_q) begin
                            state_q <= ST_END;
                        end else begin
                            byte_idx_q <= 1'b1;
                        end
                    end
                end
                ST_END: begin
                    if (tick) begin
                        case (frame_q)
                            FR_PAGE: begin
                                page_q  <= tgt_page;
                                frame_q <= (op_q == OP_READ) ? FR_READ : FR_WRITE;
                                state_q <= ST_SETUP;
                            end
                            FR_READ: begin
                                state_q <= ST_RECV;
                            end
                            default: begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RECV: begin
                    if (tick && sh_last) begin
                        rdat_q  <= sh_rx;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_PAGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && frame_q != FR_PAGE) |-> (page_q == tgt_page)); // R4
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done); // R1
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> ($past(busy) && !busy)); // R1
endmodule

// File: tb/tw3_master_test.sv
// Bench for tw3_master. A peripheral model decodes the link pins into frames.
// A behavioural reference builds the expected frames, read data and busy span.
module tw3_master_test;
    localparam int SPAN = 16;
    localparam int DW   = 8;
    localparam int AW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_op    = '0;
    logic [AW-1:0] req_addr  = '0;
    logic [7:0]    req_data  = '0;
    logic [DW-1:0] div_cfg   = '0;
    logic          sdata_i   = 1'b0;
    logic          req_ready, busy, op_done, sclk, rw_sel, sdata_o, sdata_oe;
    logic [7:0]    rd_data;

    tw3_master #(.PAGE_SPAN(SPAN), .DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .div_cfg(div_cfg), .busy(busy), .op_done(op_done), .rd_data(rd_data),
        .sclk(sclk), .rw_sel(rw_sel), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
        .sdata_i(sdata_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    int d = 1;
    bit mon_on = 0;

    // Reference state
    int rpage = 0;
    int shadow [32];
    int eph [2][16];
    int exp_q [$];
    int act_q [$];

    // Peripheral model state
    int pmem [2][16];
    int ppage = 0;
    bit prev_s = 1'b1;
    bit prev_rw = 1'b0;
    int nbits = 0;
    logic [15:0] fbits = '0;
    int lowcnt = 0;
    bit have_bit = 0;
    bit last_bit = 0;
    int rbit = 0;
    int raddr = 0;
    logic [7:0] rbyte;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int remap(input int a, input int v);
        if (a == 3) return 255 - v;
        if (a == 9) return (v < 64) ? (255 - v) : ((191 - v) & 255);
        if (a == 18) return v | 'h13;
        return v;
    endfunction

    // Peripheral model and per-cycle pin checks, sampled away from the edge.
    always @(negedge clk) begin
        if (mon_on) begin
            chk((req_ready == !busy) && (rw_sel || !sdata_oe), "R1 R3 ready/driver",
                {req_ready, busy, rw_sel, sdata_oe}, 0);
            if (rw_sel && !prev_rw) begin
                nbits = 0;
                fbits = '0;
                have_bit = 0;
            end
            if (!sclk) lowcnt++;
            if (sclk && !prev_s) begin
                chk(lowcnt == d, "R2 R12 low phase width", lowcnt, d);
                lowcnt = 0;
                if (rw_sel && sdata_oe && nbits < 16) begin
                    fbits[nbits] = sdata_o;
                    nbits++;
                    last_bit = sdata_o;
                    have_bit = 1;
                end
            end else if (sclk && prev_s && rw_sel && sdata_oe && have_bit) begin
                chk(sdata_o == last_bit, "R2 data held while high", sdata_o, last_bit);
            end
            if (!rw_sel && prev_rw) begin
                if (nbits == 16) begin
                    act_q.push_back('h10000 | (int'(fbits[7:0]) << 8) | int'(fbits[15:8]));
                    if (fbits[15:8] == 8'h01) ppage = fbits[7:0];
                    else if (ppage == 1 || ppage == 2) pmem[ppage-1][fbits[11:8]] = fbits[7:0];
                end else begin
                    act_q.push_back('h20000 | int'(fbits[7:0]));
                    raddr = fbits[3:0];
                    rbit = 0;
                end
            end
            if (!sclk && prev_s && !rw_sel) begin
                rbyte = (ppage == 1 || ppage == 2) ? 8'(pmem[ppage-1][raddr]) : 8'h00;
                sdata_i = rbyte[rbit%8];
                rbit++;
            end
            prev_s = sclk;
            prev_rw = rw_sel;
        end
    end

    task automatic do_op(input int op, input int addr, input int data, input string tag);
        int tp, la, v, pv, frames, cnt, exp_rd, a, e;
        tp = (addr >= SPAN) ? 2 : 1;
        la = addr % SPAN;
        frames = 1;
        exp_rd = 0;
        if (op == 2) v = shadow[addr] | data;
        else if (op == 3) v = shadow[addr] & ~data & 255;
        else v = data;
        if (rpage != tp) begin
            exp_q.push_back('h10000 | (tp << 8) | 1);
            rpage = tp;
            frames = 2;
        end
        if (op == 1) begin
            exp_q.push_back('h20000 | la);
            exp_rd = eph[tp-1][la];
        end else begin
            shadow[addr] = v;
            pv = remap(addr, v);
            eph[tp-1][la] = pv;
            exp_q.push_back('h10000 | (pv << 8) | la);
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_op = 2'(op);
        req_addr = AW'(addr);
        req_data = 8'(data);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!op_done && cnt < 100000) begin
            if (busy) cnt++;
            @(negedge clk);
        end
        chk(cnt == 34 * d * frames, {tag, " R1 R12 busy span"}, cnt, 34 * d * frames);
        if (op == 1) chk(rd_data == 8'(exp_rd), {tag, " R6 read data"}, rd_data, exp_rd);
        chk(act_q.size() == exp_q.size(), {tag, " R3 R4 frame count"}, act_q.size(), exp_q.size());
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            a = act_q.pop_front();
            e = exp_q.pop_front();
            chk(a == e, {tag, " frame content"}, a, e);
        end
        act_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual 150000 cycles expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = 0;
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 16; i++) begin
                eph[p][i] = 0;
                pmem[p][i] = 0;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(busy == 0 && req_ready == 1 && op_done == 0, "R1 reset handshake", {busy, req_ready, op_done}, 2);
        chk(sclk == 1, "R2 reset clock idle", sclk, 1);
        chk(rw_sel == 0 && sdata_oe == 0, "R3 reset select/driver", {rw_sel, sdata_oe}, 0);
        mon_on = 1;

        d = 1;
        do_op(0, 'h03, 'h20, "R5 R7 first access");
        do_op(0, 'h09, 'h10, "R8 fold low");
        do_op(0, 'h09, 63, "R8 fold 63");
        do_op(0, 'h09, 64, "R8 fold 64");
        do_op(0, 'h09, 191, "R8 fold 191");
        do_op(0, 'h0F, 'h3C, "R4 last page-1 address");
        do_op(0, 'h10, 'h77, "R4 first page-2 address");
        do_op(0, 'h12, 'h40, "R9 forced bits");
        do_op(0, 'h13, 'hFC, "R11 passthrough 0x13");
        do_op(1, 'h12, 0, "R6 read page 2");
        do_op(1, 'h03, 0, "R6 R4 read with switch");
        do_op(2, 'h03, 'h01, "R10 set bits");
        do_op(3, 'h12, 'h40, "R10 clear bits");
        do_op(2, 'h12, 'h00, "R10 shadow after read");
        do_op(0, 'h19, 'h05, "R11 passthrough 0x19");

        div_cfg = 8'd3;
        d = 4;
        do_op(0, 'h05, 'hA5, "R12 write slow");
        do_op(1, 'h05, 0, "R12 read slow");
        do_op(1, 'h19, 0, "R12 R6 read slow page 2");

        div_cfg = 8'd1;
        d = 2;
        do_op(3, 'h0F, 'h0C, "R12 R10 clear at div 1");

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule